// File: doc/BRIEF.md
# MSI blocking L1 cache controller

This block is a small direct-mapped first-level cache that keeps an MSI permission state (Invalid, Shared, Modified) on every one-word line. It serves one processor request at a time. A load may hit in Shared or Modified. A store writes in place only when the line is Modified. Every other case runs through a miss sequencer that steps through idle, victim eviction, fill request, fill wait and response, then returns to idle.

The block talks to its parent over two message channels. The upward channel carries eviction and downgrade responses as well as fill requests. The downward channel carries fill responses and downgrade requests. Each message holds a request/response flag, an address, a target state and a data word. The parent may send a downgrade request at any time, and the sequencer keeps serving these in every step except the response step. When a downgrade response and a request of the block's own compete for the upward channel, the response goes first. Backpressure on the upward channel freezes all state until the message is taken.

Top module: `msi_l1_ctrl`

## Requirements
- R1: After reset every line is Invalid and the sequencer is idle: `preq_ready` is 1, while `presp_valid` and `up_valid` are 0. The first access to any address is a miss.
- R2: An accepted load whose line tag matches, in state S or M, returns the stored word on `presp_data` with `presp_valid` high one cycle after acceptance, and sends no upward message.
- R3: An accepted store to a matching line in M updates the stored word. It produces no processor response and no upward message.
- R4: A store to a matching line in S leaves the data unchanged, sends no eviction and issues a fill request (`up_is_resp`=0) for the same address with target state M (encoding 2) in the cycle after acceptance.
- R5: On a miss whose indexed line is not Invalid, the block first sends a response (`up_is_resp`=1) with target state I (0) for the victim address {victim tag, index}. Its data is the stored word if the victim was M and zero if it was S. The victim becomes Invalid.
- R6: A fill request asks for S (1) on a load and for M (2) on a store. When the victim is Invalid, no eviction is sent and the fill request follows one idle cycle later.
- R7: A fill response (`dn_is_resp`=1) installs the granted state and the missed address. The stored word becomes the returned data for a load and the store data for a store. A load miss presents its word on `presp_data` two cycles after the fill response is taken.
- R8: A downgrade request (`dn_is_resp`=0) to state y, on a line whose tag matches and whose state is above y, sends a response with state y and address of the request. Its data is the stored word if the line was M and zero otherwise, and the line becomes y. In any other case the request is consumed with no upward message and no change.
- R9: Downgrade requests are accepted in every sequencer step except the response step, where `dn_ready` is 0 for them.
- R10: While a downgrade request is pending, no eviction or fill request is offered upward. A downgrade response is always sent ahead of them.
- R11: While `up_valid` is 1 and `up_ready` is 0, the sequencer step and all line contents stay unchanged.
- R12: `preq_ready` is 1 only in the idle step. During a miss it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| preq_valid | input | 1 | Processor request valid |
| preq_ready | output | 1 | Processor request accepted when high with valid |
| preq_store | input | 1 | 1 = store, 0 = load |
| preq_addr | input | ADDR_W | Word address: low bits index, high bits tag |
| preq_wdata | input | DATA_W | Store data |
| presp_valid | output | 1 | Load data valid |
| presp_ready | input | 1 | Processor takes load data |
| presp_data | output | DATA_W | Load data |
| up_valid | output | 1 | Upward message valid |
| up_ready | input | 1 | Parent accepts upward message |
| up_is_resp | output | 1 | 1 = response (eviction or downgrade), 0 = fill request |
| up_addr | output | ADDR_W | Message address |
| up_state | output | 2 | Target state: 0 = I, 1 = S, 2 = M |
| up_data | output | DATA_W | Message data (zero when no dirty word) |
| dn_valid | input | 1 | Downward message valid |
| dn_ready | output | 1 | Block consumes downward message |
| dn_is_resp | input | 1 | 1 = fill response, 0 = downgrade request |
| dn_addr | input | ADDR_W | Message address |
| dn_state | input | 2 | Granted or requested state, same encoding as up_state |
| dn_data | input | DATA_W | Fill data |

## Verification
A load hit is due on the processor port one cycle after the acceptance edge. On a miss the eviction is offered in the first cycle after acceptance, the fill request in the next, and the load word two cycles after the fill response is taken. A store upgrade skips the eviction cycle. The bench drives every input just after a falling edge. It samples outputs a moment later in the same low phase, so each sample sees the values registered at the preceding rising edge. A behavioural model of the line states, tags and words predicts each expected message and word at those points. Downgrade requests are injected in the eviction step, the fill wait and the response step, and an upward stall is held for a cycle, to check the ordering and freeze rules at the exact cycle they apply.

// File: rtl/msi_l1_pkg.sv
package msi_l1_pkg;

   // Permission order: M > S > I (numeric compare is used)
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_M = 2'd2
   } lst_e;

   typedef enum logic [2:0] {
      MS_READY    = 3'd0,
      MS_START    = 3'd1,
      MS_FILLREQ  = 3'd2,
      MS_WAITFILL = 3'd3,
      MS_RESP     = 3'd4
   } mshr_e;

endpackage

// File: rtl/msi_l1_lines.sv
module msi_l1_lines
   import msi_l1_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int TAG_W  = 5,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ra_idx,
   output lst_e              ra_st,
   output logic [TAG_W-1:0]  ra_tag,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output lst_e              rb_st,
   output logic [TAG_W-1:0]  rb_tag,
   output logic [DATA_W-1:0] rb_data,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic              we_st,
   input  logic              we_tag,
   input  logic              we_data,
   input  lst_e              w_st,
   input  logic [TAG_W-1:0]  w_tag,
   input  logic [DATA_W-1:0] w_data
);

   lst_e              st_q   [LINES];
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic sel;
      assign sel = (w_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g] <= ST_I;
         end else if (we_st && sel) begin
            st_q[g] <= w_st;
         end
      end

      always_ff @(posedge clk) begin
         if (we_tag && sel) tag_q[g] <= w_tag;
         if (we_data && sel) data_q[g] <= w_data;
      end
   end

   assign ra_st   = st_q[ra_idx];
   assign ra_tag  = tag_q[ra_idx];
   assign ra_data = data_q[ra_idx];
   assign rb_st   = st_q[rb_idx];
   assign rb_tag  = tag_q[rb_idx];
   assign rb_data = data_q[rb_idx];

endmodule

// File: rtl/msi_l1_dnsvc.sv
module msi_l1_dnsvc
   import msi_l1_pkg::*;
#(
   parameter int TAG_W  = 5,
   parameter int DATA_W = 32
) (
   input  lst_e              line_st,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   input  logic [TAG_W-1:0]  req_tag,
   input  lst_e              req_st,
   output logic              send,
   output logic [DATA_W-1:0] send_data
);

   logic present;
   assign present   = (line_st != ST_I) && (line_tag == req_tag);
   assign send      = present && (line_st > req_st);
   assign send_data = (line_st == ST_M) ? line_data : '0;

endmodule

// File: rtl/msi_l1_upsel.sv
module msi_l1_upsel
   import msi_l1_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              dr_v,
   input  logic [ADDR_W-1:0] dr_addr,
   input  lst_e              dr_st,
   input  logic [DATA_W-1:0] dr_data,
   input  logic              ev_v,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DATA_W-1:0] ev_data,
   input  logic              fr_v,
   input  logic [ADDR_W-1:0] fr_addr,
   input  lst_e              fr_st,
   output logic              up_valid,
   output logic              up_is_resp,
   output logic [ADDR_W-1:0] up_addr,
   output lst_e              up_st,
   output logic [DATA_W-1:0] up_data
);

   // Responses first (downgrade, then eviction), fill request last
   always_comb begin
      up_valid   = dr_v || ev_v || fr_v;
      up_is_resp = 1'b0;
      up_addr    = fr_addr;
      up_st      = fr_st;
      up_data    = '0;
      if (dr_v) begin
         up_is_resp = 1'b1;
         up_addr    = dr_addr;
         up_st      = dr_st;
         up_data    = dr_data;
      end else if (ev_v) begin
         up_is_resp = 1'b1;
         up_addr    = ev_addr;
         up_st      = ST_I;
         up_data    = ev_data;
      end
   end

endmodule

// File: rtl/msi_l1_ctrl.sv
module msi_l1_ctrl
   import msi_l1_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preq_valid,
   output logic              preq_ready,
   input  logic              preq_store,
   input  logic [ADDR_W-1:0] preq_addr,
   input  logic [DATA_W-1:0] preq_wdata,
   output logic              presp_valid,
   input  logic              presp_ready,
   output logic [DATA_W-1:0] presp_data,
   output logic              up_valid,
   input  logic              up_ready,
   output logic              up_is_resp,
   output logic [ADDR_W-1:0] up_addr,
   output logic [1:0]        up_state,
   output logic [DATA_W-1:0] up_data,
   input  logic              dn_valid,
   output logic              dn_ready,
   input  logic              dn_is_resp,
   input  logic [ADDR_W-1:0] dn_addr,
   input  logic [1:0]        dn_state,
   input  logic [DATA_W-1:0] dn_data
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   mshr_e             mshr_q, mshr_d;
   logic              mst_q;
   logic [ADDR_W-1:0] maddr_q;
   logic [DATA_W-1:0] mwd_q;
   logic              rsp_v_q;
   logic [DATA_W-1:0] rsp_d_q;

   logic [IDX_W-1:0]  p_idx, m_idx, d_idx, a_idx, w_idx;
   logic [TAG_W-1:0]  p_tag, m_tag, d_tag, a_tag, b_tag, w_tag;
   lst_e              a_st, b_st, w_st, dn_y, fr_st, up_st_e;
   logic [DATA_W-1:0] a_data, b_data, w_data, dr_data, ev_data;
   logic              we_st, we_tag, we_data;

   assign p_idx = preq_addr[IDX_W-1:0];
   assign p_tag = preq_addr[ADDR_W-1:IDX_W];
   assign m_idx = maddr_q[IDX_W-1:0];
   assign m_tag = maddr_q[ADDR_W-1:IDX_W];
   assign d_idx = dn_addr[IDX_W-1:0];
   assign d_tag = dn_addr[ADDR_W-1:IDX_W];
   assign a_idx = (mshr_q == MS_READY) ? p_idx : m_idx;
   assign dn_y  = lst_e'(dn_state);

   msi_l1_lines #(
      .LINES (LINES),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) u_lines (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (a_idx),
      .ra_st  (a_st),
      .ra_tag (a_tag),
      .ra_data(a_data),
      .rb_idx (d_idx),
      .rb_st  (b_st),
      .rb_tag (b_tag),
      .rb_data(b_data),
      .w_idx  (w_idx),
      .we_st  (we_st),
      .we_tag (we_tag),
      .we_data(we_data),
      .w_st   (w_st),
      .w_tag  (w_tag),
      .w_data (w_data)
   );

   logic dn_send;

   msi_l1_dnsvc #(
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) u_dnsvc (
      .line_st  (b_st),
      .line_tag (b_tag),
      .line_data(b_data),
      .req_tag  (d_tag),
      .req_st   (dn_y),
      .send     (dn_send),
      .send_data(dr_data)
   );

   logic hit, acc, dn_req, dn_fire, ev_need, ev_v, fr_v, fill_fire, rsp_free;

   assign hit       = (a_st != ST_I) && (a_tag == p_tag);
   assign dn_req    = dn_valid && !dn_is_resp && (mshr_q != MS_RESP);
   assign dn_fire   = dn_req && (!dn_send || up_ready);
   assign rsp_free  = !rsp_v_q || presp_ready;
   assign preq_ready = (mshr_q == MS_READY) && !dn_valid && rsp_free;
   assign acc       = preq_valid && preq_ready;
   assign ev_need   = (a_st != ST_I);
   assign ev_v      = (mshr_q == MS_START) && !dn_req && ev_need;
   assign fr_v      = (mshr_q == MS_FILLREQ) && !dn_req;
   assign fill_fire = dn_valid && dn_is_resp && (mshr_q == MS_WAITFILL);
   assign ev_data   = (a_st == ST_M) ? a_data : '0;
   assign fr_st     = mst_q ? ST_M : ST_S;

   assign dn_ready = dn_is_resp ? (mshr_q == MS_WAITFILL)
                                : ((mshr_q != MS_RESP) && (!dn_send || up_ready));

   msi_l1_upsel #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_upsel (
      .dr_v      (dn_req && dn_send),
      .dr_addr   (dn_addr),
      .dr_st     (dn_y),
      .dr_data   (dr_data),
      .ev_v      (ev_v),
      .ev_addr   ({a_tag, m_idx}),
      .ev_data   (ev_data),
      .fr_v      (fr_v),
      .fr_addr   (maddr_q),
      .fr_st     (fr_st),
      .up_valid  (up_valid),
      .up_is_resp(up_is_resp),
      .up_addr   (up_addr),
      .up_st     (up_st_e),
      .up_data   (up_data)
   );
   assign up_state = up_st_e;

   // Sequencer and single line-write port; sources are mutually exclusive
   always_comb begin
      mshr_d  = mshr_q;
      we_st   = 1'b0;
      we_tag  = 1'b0;
      we_data = 1'b0;
      w_idx   = a_idx;
      w_st    = ST_I;
      w_tag   = m_tag;
      w_data  = preq_wdata;
      unique case (mshr_q)
         MS_READY: begin
            if (acc && preq_store) begin
               if (hit && a_st == ST_M) begin
                  we_data = 1'b1;
               end else if (hit) begin
                  mshr_d = MS_FILLREQ;
               end else begin
                  mshr_d = MS_START;
               end
            end else if (acc && !hit) begin
               mshr_d = MS_START;
            end
         end
         MS_START: begin
            if (!dn_req) begin
               if (!ev_need) begin
                  mshr_d = MS_FILLREQ;
               end else if (up_ready) begin
                  we_st  = 1'b1;
                  mshr_d = MS_FILLREQ;
               end
            end
         end
         MS_FILLREQ: begin
            if (fr_v && up_ready) mshr_d = MS_WAITFILL;
         end
         MS_WAITFILL: begin
            if (fill_fire) begin
               we_st   = 1'b1;
               we_tag  = 1'b1;
               we_data = 1'b1;
               w_st    = dn_y;
               w_data  = mst_q ? mwd_q : dn_data;
               mshr_d  = MS_RESP;
            end
         end
         MS_RESP: begin
            if (mst_q || rsp_free) mshr_d = MS_READY;
         end
         default: mshr_d = MS_READY;
      endcase
      if (dn_fire && dn_send) begin
         we_st = 1'b1;
         w_idx = d_idx;
         w_st  = dn_y;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mshr_q  <= MS_READY;
         mst_q   <= 1'b0;
         maddr_q <= '0;
         mwd_q   <= '0;
      end else begin
         mshr_q <= mshr_d;
         if (acc) begin
            mst_q   <= preq_store;
            maddr_q <= preq_addr;
            mwd_q   <= preq_wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else if (acc && hit && !preq_store) begin
         rsp_v_q <= 1'b1;
         rsp_d_q <= a_data;
      end else if (mshr_q == MS_RESP && !mst_q && rsp_free) begin
         rsp_v_q <= 1'b1;
         rsp_d_q <= a_data;
      end else if (presp_ready) begin
         rsp_v_q <= 1'b0;
      end
   end

   assign presp_valid = rsp_v_q;
   assign presp_data  = rsp_d_q;

endmodule

// File: rtl/msi_l1_ctrl_chk.sv
module msi_l1_ctrl_chk
   import msi_l1_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mshr,
   input logic       mreq_store,
   input logic       preq_ready,
   input logic       presp_valid,
   input logic       up_valid,
   input logic       up_ready,
   input logic       up_is_resp,
   input logic [1:0] up_state,
   input logic       dn_valid,
   input logic       dn_ready,
   input logic       dn_is_resp
);

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (mshr == MS_READY) && !presp_valid);

   p_fill_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_is_resp) |-> (up_state == (mreq_store ? 2'd2 : 2'd1)));

   p_evict_to_i_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && mshr == MS_START && !(dn_valid && !dn_is_resp)) |->
         (up_is_resp && up_state == 2'd0));

   p_resp_blocks_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mshr == MS_RESP) |-> !(dn_ready && !dn_is_resp));

   p_dn_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_is_resp && mshr != MS_RESP) |-> !(up_valid && !up_is_resp));

   p_stall_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_ready) |=> $stable(mshr));

   p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      preq_ready |-> (mshr == MS_READY));

endmodule

bind msi_l1_ctrl msi_l1_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mshr       (mshr_q),
   .mreq_store (mst_q),
   .preq_ready (preq_ready),
   .presp_valid(presp_valid),
   .up_valid   (up_valid),
   .up_ready   (up_ready),
   .up_is_resp (up_is_resp),
   .up_state   (up_state),
   .dn_valid   (dn_valid),
   .dn_ready   (dn_ready),
   .dn_is_resp (dn_is_resp)
);

// File: tb/msi_l1_ctrl_tb.sv
module msi_l1_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        preq_valid = 1'b0, preq_store = 1'b0;
   logic [7:0]  preq_addr = '0;
   logic [31:0] preq_wdata = '0;
   logic        preq_ready, presp_valid;
   logic        presp_ready = 1'b1;
   logic [31:0] presp_data;
   logic        up_valid, up_is_resp;
   logic        up_ready = 1'b1;
   logic [7:0]  up_addr;
   logic [1:0]  up_state;
   logic [31:0] up_data;
   logic        dn_valid = 1'b0, dn_is_resp = 1'b0;
   logic        dn_ready;
   logic [7:0]  dn_addr = '0;
   logic [1:0]  dn_state = '0;
   logic [31:0] dn_data = '0;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // behavioural model of the lines
   logic [1:0]  mst [8];
   logic [4:0]  mtg [8];
   logic [31:0] mdt [8];

   always #10 clk = ~clk;

   msi_l1_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .preq_valid(preq_valid), .preq_ready(preq_ready), .preq_store(preq_store),
      .preq_addr(preq_addr), .preq_wdata(preq_wdata),
      .presp_valid(presp_valid), .presp_ready(presp_ready), .presp_data(presp_data),
      .up_valid(up_valid), .up_ready(up_ready), .up_is_resp(up_is_resp),
      .up_addr(up_addr), .up_state(up_state), .up_data(up_data),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_is_resp(dn_is_resp),
      .dn_addr(dn_addr), .dn_state(dn_state), .dn_data(dn_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Caller stands just after a falling edge; returns just after the next one.
   task automatic dn_op(input logic [7:0] a, input logic [1:0] y, input string req);
      int i = a[2:0];
      bit send = (mst[i] != 2'd0) && (mtg[i] == a[7:3]) && (mst[i] > y);
      logic [31:0] d = (mst[i] == 2'd2) ? mdt[i] : 32'd0;
      dn_valid = 1'b1; dn_is_resp = 1'b0; dn_addr = a; dn_state = y;
      #1;
      chk(dn_ready == 1'b1, req, {63'd0, dn_ready}, 64'd1);
      if (send)
         chk(up_valid && up_is_resp && up_addr == a && up_state == y && up_data == d, req,
             {up_valid, up_is_resp, up_state, up_addr, up_data},
             {1'b1, 1'b1, y, a, d});
      else
         chk(!up_valid, req, {63'd0, up_valid}, 64'd0);
      tick();
      dn_valid = 1'b0;
      if (send) mst[i] = y;
      #1;
   endtask

   task automatic downgrade(input logic [7:0] a, input logic [1:0] y, input string req);
      @(negedge clk);
      dn_op(a, y, req);
   endtask

   // inj: 0 none, 1 during eviction step, 2 during fill wait
   task automatic access(input bit st, input logic [7:0] a, input logic [31:0] wd,
                         input logic [31:0] fd, input int inj, input logic [7:0] ia,
                         input logic [1:0] iy, input bit stall, input bit probe);
      int i = a[2:0];
      bit hit = (mst[i] != 2'd0) && (mtg[i] == a[7:3]);
      logic [1:0] gst = st ? 2'd2 : 2'd1;
      @(negedge clk);
      preq_valid = 1'b1; preq_store = st; preq_addr = a; preq_wdata = wd;
      #1;
      chk(preq_ready == 1'b1, "R12 idle ready", {63'd0, preq_ready}, 64'd1);
      tick();
      preq_valid = 1'b0;
      #1;
      if (hit && (!st || mst[i] == 2'd2)) begin
         if (st) begin
            mdt[i] = wd;
            chk(!up_valid && !presp_valid, "R3 store hit silent",
                {62'd0, up_valid, presp_valid}, 64'd0);
         end else begin
            chk(presp_valid && presp_data == mdt[i], "R2 load hit",
                {presp_valid, presp_data}, {1'b1, mdt[i]});
            chk(!up_valid, "R2 no upward msg", {63'd0, up_valid}, 64'd0);
         end
         return;
      end
      if (!hit) begin
         if (inj == 1) dn_op(ia, iy, "R10 downgrade first");
         if (mst[i] != 2'd0) begin
            logic [31:0] ed = (mst[i] == 2'd2) ? mdt[i] : 32'd0;
            chk(up_valid && up_is_resp && up_state == 2'd0 && up_addr == {mtg[i], 3'(i)}
                && up_data == ed, "R5 eviction",
                {up_valid, up_is_resp, up_state, up_addr, up_data},
                {1'b1, 1'b1, 2'd0, mtg[i], 3'(i), ed});
            mst[i] = 2'd0;
         end else begin
            chk(!up_valid, "R6 no eviction of invalid", {63'd0, up_valid}, 64'd0);
         end
         tick();
         #1;
      end
      chk(up_valid && !up_is_resp && up_addr == a && up_state == gst,
          st ? "R4 R6 fill request M" : "R6 fill request S",
          {up_valid, up_is_resp, up_state, up_addr}, {1'b1, 1'b0, gst, a});
      if (stall) begin
         up_ready = 1'b0;
         tick();
         #1;
         chk(up_valid && !up_is_resp && up_addr == a && up_state == gst, "R11 held under stall",
             {up_valid, up_is_resp, up_state, up_addr}, {1'b1, 1'b0, gst, a});
         up_ready = 1'b1;
      end
      tick();
      #1;
      chk(!preq_ready, "R12 busy during miss", {63'd0, preq_ready}, 64'd0);
      chk(!up_valid, "R6 single fill request", {63'd0, up_valid}, 64'd0);
      if (inj == 2) dn_op(ia, iy, "R9 downgrade in fill wait");
      dn_valid = 1'b1; dn_is_resp = 1'b1; dn_addr = a; dn_state = gst; dn_data = fd;
      #1;
      chk(dn_ready == 1'b1, "R7 fill taken", {63'd0, dn_ready}, 64'd1);
      tick();
      dn_valid = 1'b0; dn_is_resp = 1'b0;
      mst[i] = gst; mtg[i] = a[7:3]; mdt[i] = st ? wd : fd;
      if (probe) begin
         dn_valid = 1'b1; dn_is_resp = 1'b0; dn_addr = 8'h7F; dn_state = 2'd0;
         #1;
         chk(!dn_ready, "R9 blocked in response step", {63'd0, dn_ready}, 64'd0);
      end
      tick();
      #1;
      if (!st)
         chk(presp_valid && presp_data == mdt[i], "R7 load miss data",
             {presp_valid, presp_data}, {1'b1, mdt[i]});
      else
         chk(!presp_valid, "R7 store miss no response", {63'd0, presp_valid}, 64'd0);
      if (probe) begin
         chk(dn_ready && !up_valid, "R8 probe dropped",
             {62'd0, dn_ready, up_valid}, {62'd0, 2'b10});
         tick();
         dn_valid = 1'b0;
      end
   endtask

   initial begin
      for (int k = 0; k < 8; k++) begin
         mst[k] = 2'd0; mtg[k] = '0; mdt[k] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(preq_ready && !presp_valid && !up_valid, "R1 reset state",
          {61'd0, preq_ready, presp_valid, up_valid}, {61'd0, 3'b100});

      access(0, 8'h11, 0, 32'hA1A1_0001, 0, 0, 0, 0, 0);       // R1 R6 R7
      access(0, 8'h11, 0, 0, 0, 0, 0, 0, 0);                   // R2 hit in S
      access(1, 8'h11, 32'hB1B1_0002, 32'hDEAD_BEEF, 0, 0, 0, 1, 0); // R4 R11
      access(0, 8'h11, 0, 0, 0, 0, 0, 0, 0);                   // R7 store data kept
      access(1, 8'h11, 32'hC1C1_0003, 0, 0, 0, 0, 0, 0);       // R3
      access(0, 8'h11, 0, 0, 0, 0, 0, 0, 0);                   // R2 hit in M
      access(0, 8'h19, 0, 32'hD1D1_0004, 0, 0, 0, 0, 0);       // R5 dirty victim
      access(0, 8'h21, 0, 32'hE1E1_0005, 0, 0, 0, 0, 0);       // R5 clean victim
      downgrade(8'h21, 2'd0, "R8 S to I");
      access(0, 8'h29, 0, 32'hA9A9_0006, 0, 0, 0, 0, 0);       // R6 invalid victim
      access(1, 8'h35, 32'hF5F5_0007, 32'h1234_5678, 0, 0, 0, 0, 0);
      downgrade(8'h35, 2'd1, "R8 M to S with data");
      access(0, 8'h35, 0, 0, 0, 0, 0, 0, 0);                   // R2 after downgrade
      downgrade(8'h35, 2'd1, "R8 already S dropped");
      downgrade(8'h3D, 2'd0, "R8 tag mismatch dropped");
      access(1, 8'h45, 32'h4545_0008, 32'h0BAD_0BAD, 1, 8'h29, 2'd0, 0, 0); // R10
      access(0, 8'h52, 0, 32'h5252_0009, 2, 8'h45, 2'd1, 0, 1); // R9
      access(0, 8'h45, 0, 0, 0, 0, 0, 0, 0);                   // R8 S keeps data
      access(0, 8'h52, 0, 0, 0, 0, 0, 0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule